// File: doc/BRIEF.md
# TLB Address Translation Unit

This block turns 32-bit virtual addresses into physical addresses with a small, fully associative translation buffer of page mappings. Each address splits into a 20-bit virtual page number (bits 31:12) and a 12-bit page offset (bits 11:0), so a page is 4 KB. The page number is compared against every stored entry in parallel. When the matching entry's page is marked as loaded, the unit returns the stored physical page number with the offset attached unchanged. The unit raises one fault when no entry matches and a different fault when an entry matches but its page has not been brought into memory yet.

Software that acts as the operating system keeps the buffer filled through a refill port. The port has no slot index. The unit places a new mapping in the lowest-numbered empty slot. If every slot is in use, it replaces the next entry in round-robin order that is not marked resident. Resident entries are pinned and are never replaced. A separate mark port sets the loaded flag of mappings that already exist once their page is in memory. Page-table walks, fault handling and the memory itself are outside this block.

Top module: `xlate_unit`

## Requirements
- R1: After reset every entry is invalid, `rsp_valid`, `fill_done` and `fill_reject` are 0, and the first lookup reports a miss fault.
- R2: A request sampled at a clock edge produces `rsp_valid` = 1 from the next edge. On a hit whose loaded flag is 1, `rsp_hit` = 1 and `rsp_paddr` = {stored physical page number, `req_vaddr[11:0]`}.
- R3: When a valid entry matches but its loaded flag is 0, the response has `rsp_unloaded_fault` = 1, `rsp_hit` = 0 and `rsp_paddr` = 0.
- R4: When no valid entry matches `req_vaddr[31:12]`, the response has `rsp_miss_fault` = 1, `rsp_hit` = 0 and `rsp_paddr` = 0.
- R5: While `rsp_valid` is 1, exactly one of `rsp_hit`, `rsp_miss_fault` and `rsp_unloaded_fault` is 1. While it is 0, all three are 0.
- R6: While an invalid entry exists, a refill goes into the lowest-index invalid entry, and every mapping already stored still hits.
- R7: When all entries are valid, a refill replaces the first non-resident entry at or after a round-robin pointer. The pointer starts at entry 0 after reset and moves to one past the replaced entry.
- R8: An entry written with its resident flag set is never replaced. The round-robin search skips it.
- R9: If every entry is valid and resident, a refill is rejected and no stored mapping changes.
- R10: A mark request sets the loaded flag of every valid entry whose page number equals `mark_vpn`. A mark of a page number that is not stored changes nothing.
- R11: If more than one valid entry matches, the lowest-index entry supplies the result.
- R12: A refill request is answered one cycle later by a one-cycle pulse of exactly one of `fill_done` and `fill_reject`. Neither pulses without a request.
- R13: A lookup sees the table as it stood before any refill or mark taken at the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | Lookup result present (one cycle after the request) |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_paddr | output | 32 | Physical address on a hit, otherwise 0 |
| rsp_miss_fault | output | 1 | No entry maps the page |
| rsp_unloaded_fault | output | 1 | Page mapped but not loaded |
| fill_valid | input | 1 | Refill request strobe |
| fill_vpn | input | 20 | Virtual page number of the new mapping |
| fill_ppn | input | 20 | Physical page number of the new mapping |
| fill_loaded | input | 1 | Loaded flag of the new mapping |
| fill_resident | input | 1 | Resident (pinned) flag of the new mapping |
| fill_done | output | 1 | Refill accepted (pulse) |
| fill_reject | output | 1 | Refill rejected because all entries are resident (pulse) |
| mark_valid | input | 1 | Set-loaded request strobe |
| mark_vpn | input | 20 | Page number whose loaded flag is set |

## Verification
A wrong valid, resident or loaded bit inside the table shows at the ports only when that page is looked up. It then appears one cycle after the request as the wrong one of hit, miss fault and unloaded fault. A round-robin pointer that has drifted stays hidden until the buffer is full. At the next refill it shows as the wrong mapping disappearing, so the bench fills the table completely and then looks up every neighbour of the expected victim. Duplicate entries and a refill in the same cycle as a lookup are exercised because they expose the priority order and the read-before-write timing of the table.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

  // Outcome of one lookup, computed before the response registers
  typedef enum logic [1:0] {
    XL_NONE     = 2'd0,
    XL_HIT      = 2'd1,
    XL_UNLOADED = 2'd2,
    XL_MISS     = 2'd3
  } xl_outcome_t;

  localparam int XL_ADDR_W  = 32;
  localparam int XL_OFS_W   = 12;
  localparam int XL_ENTRIES = 8;

endpackage

// File: rtl/xlate_prio_pick.sv
// Lowest-index set bit of a request vector
module xlate_prio_pick #(
  parameter int N     = 8,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  output logic             found,
  output logic [IDX_W-1:0] idx
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req[k]) begin
        found = 1'b1;
        idx   = IDX_W'(k);
      end
    end
  end

endmodule

// File: rtl/xlate_victim_rr.sv
// Round-robin victim choice that skips pinned entries
module xlate_victim_rr #(
  parameter int N     = 8,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     pinned,
  input  logic             advance,
  output logic             found,
  output logic [IDX_W-1:0] victim
);

  logic [IDX_W-1:0] ptr_q;

  always_comb begin
    int j;
    found  = 1'b0;
    victim = '0;
    j      = 0;
    for (int k = N - 1; k >= 0; k--) begin
      j = (int'(ptr_q) + k) % N;
      if (!pinned[j]) begin
        found  = 1'b1;
        victim = IDX_W'(j);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (advance && found) begin
      if (int'(victim) == N - 1) ptr_q <= '0;
      else                       ptr_q <= victim + IDX_W'(1);
    end
  end

endmodule

// File: rtl/xlate_entry_store.sv
// Entry array with parallel page-number compare
module xlate_entry_store #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic [IDX_W-1:0]              wr_idx,
  input  logic [VPN_W-1:0]              wr_vpn,
  input  logic [PPN_W-1:0]              wr_ppn,
  input  logic                          wr_loaded,
  input  logic                          wr_resident,
  input  logic                          mark_en,
  input  logic [VPN_W-1:0]              mark_vpn,
  input  logic [VPN_W-1:0]              lk_vpn,
  output logic [ENTRIES-1:0]            lk_match,
  output logic [ENTRIES-1:0]            valid_vec,
  output logic [ENTRIES-1:0]            resident_vec,
  output logic [ENTRIES-1:0]            loaded_vec,
  output logic [ENTRIES-1:0][PPN_W-1:0] ppn_arr
);

  logic [VPN_W-1:0] vpn_q [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic sel_wr;
    logic mark_hit;

    assign sel_wr   = wr_en && (wr_idx == IDX_W'(i));
    assign mark_hit = mark_en && valid_vec[i] && (vpn_q[i] == mark_vpn);
    assign lk_match[i] = valid_vec[i] && (vpn_q[i] == lk_vpn);

    // flags: reset to a known state
    always_ff @(posedge clk) begin
      if (rst) begin
        valid_vec[i]    <= 1'b0;
        resident_vec[i] <= 1'b0;
        loaded_vec[i]   <= 1'b0;
      end else if (sel_wr) begin
        valid_vec[i]    <= 1'b1;
        resident_vec[i] <= wr_resident;
        loaded_vec[i]   <= wr_loaded;
      end else if (mark_hit) begin
        loaded_vec[i]   <= 1'b1;
      end
    end

    // page numbers: no reset, only meaningful while valid
    always_ff @(posedge clk) begin
      if (sel_wr) begin
        vpn_q[i]   <= wr_vpn;
        ppn_arr[i] <= wr_ppn;
      end
    end
  end

endmodule

// File: rtl/xlate_unit.sv
module xlate_unit
  import xlate_pkg::*;
#(
  parameter int ADDR_W  = XL_ADDR_W,
  parameter int OFS_W   = XL_OFS_W,
  parameter int ENTRIES = XL_ENTRIES
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic [ADDR_W-1:0]   req_vaddr,
  output logic                rsp_valid,
  output logic                rsp_hit,
  output logic [ADDR_W-1:0]   rsp_paddr,
  output logic                rsp_miss_fault,
  output logic                rsp_unloaded_fault,
  input  logic                fill_valid,
  input  logic [ADDR_W-OFS_W-1:0] fill_vpn,
  input  logic [ADDR_W-OFS_W-1:0] fill_ppn,
  input  logic                fill_loaded,
  input  logic                fill_resident,
  output logic                fill_done,
  output logic                fill_reject,
  input  logic                mark_valid,
  input  logic [ADDR_W-OFS_W-1:0] mark_vpn
);

  localparam int PN_W  = ADDR_W - OFS_W;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [PN_W-1:0]              lk_vpn;
  logic [OFS_W-1:0]             lk_ofs;
  logic [ENTRIES-1:0]           lk_match;
  logic [ENTRIES-1:0]           valid_vec;
  logic [ENTRIES-1:0]           resident_vec;
  logic [ENTRIES-1:0]           loaded_vec;
  logic [ENTRIES-1:0][PN_W-1:0] ppn_arr;

  logic             hit_found;
  logic [IDX_W-1:0] hit_idx;
  logic             free_found;
  logic [IDX_W-1:0] free_idx;
  logic             rr_found;
  logic [IDX_W-1:0] victim_idx;
  logic             fill_ok;
  logic             evict_en;
  logic [IDX_W-1:0] wr_idx;
  xl_outcome_t      outcome;

  assign lk_vpn = req_vaddr[ADDR_W-1:OFS_W];
  assign lk_ofs = req_vaddr[OFS_W-1:0];

  xlate_entry_store #(
    .ENTRIES(ENTRIES), .VPN_W(PN_W), .PPN_W(PN_W), .IDX_W(IDX_W)
  ) u_store (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (fill_ok),
    .wr_idx       (wr_idx),
    .wr_vpn       (fill_vpn),
    .wr_ppn       (fill_ppn),
    .wr_loaded    (fill_loaded),
    .wr_resident  (fill_resident),
    .mark_en      (mark_valid),
    .mark_vpn     (mark_vpn),
    .lk_vpn       (lk_vpn),
    .lk_match     (lk_match),
    .valid_vec    (valid_vec),
    .resident_vec (resident_vec),
    .loaded_vec   (loaded_vec),
    .ppn_arr      (ppn_arr)
  );

  xlate_prio_pick #(.N(ENTRIES), .IDX_W(IDX_W)) u_hit_pick (
    .req   (lk_match),
    .found (hit_found),
    .idx   (hit_idx)
  );

  xlate_prio_pick #(.N(ENTRIES), .IDX_W(IDX_W)) u_free_pick (
    .req   (~valid_vec),
    .found (free_found),
    .idx   (free_idx)
  );

  xlate_victim_rr #(.N(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk     (clk),
    .rst     (rst),
    .pinned  (resident_vec),
    .advance (evict_en),
    .found   (rr_found),
    .victim  (victim_idx)
  );

  assign fill_ok  = fill_valid && (free_found || rr_found);
  assign evict_en = fill_valid && !free_found && rr_found;
  assign wr_idx   = free_found ? free_idx : victim_idx;

  always_comb begin
    if (!req_valid)                outcome = XL_NONE;
    else if (!hit_found)           outcome = XL_MISS;
    else if (loaded_vec[hit_idx])  outcome = XL_HIT;
    else                           outcome = XL_UNLOADED;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid          <= 1'b0;
      rsp_hit            <= 1'b0;
      rsp_miss_fault     <= 1'b0;
      rsp_unloaded_fault <= 1'b0;
      rsp_paddr          <= '0;
      fill_done          <= 1'b0;
      fill_reject        <= 1'b0;
    end else begin
      rsp_valid          <= (outcome != XL_NONE);
      rsp_hit            <= (outcome == XL_HIT);
      rsp_miss_fault     <= (outcome == XL_MISS);
      rsp_unloaded_fault <= (outcome == XL_UNLOADED);
      rsp_paddr          <= (outcome == XL_HIT) ? {ppn_arr[hit_idx], lk_ofs} : '0;
      fill_done          <= fill_ok;
      fill_reject        <= fill_valid && !fill_ok;
    end
  end

endmodule

// File: rtl/xlate_checker.sv
module xlate_checker #(
  parameter int ADDR_W  = 32,
  parameter int OFS_W   = 12,
  parameter int ENTRIES = 8,
  parameter int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic [ADDR_W-1:0]  req_vaddr,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic [ADDR_W-1:0]  rsp_paddr,
  input logic               rsp_miss_fault,
  input logic               rsp_unloaded_fault,
  input logic               fill_valid,
  input logic               fill_done,
  input logic               fill_reject,
  input logic               evict_en,
  input logic [IDX_W-1:0]   victim_idx,
  input logic [ENTRIES-1:0] resident_vec
);

  a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  a_r2_no_rsp_without_req: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  a_r2_offset_kept: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (!rsp_hit || rsp_paddr[OFS_W-1:0] == $past(req_vaddr[OFS_W-1:0])));

  a_r5_one_outcome: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $countones({rsp_hit, rsp_miss_fault, rsp_unloaded_fault}) == 1);

  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> !(rsp_hit || rsp_miss_fault || rsp_unloaded_fault));

  a_r3_fault_paddr_zero: assert property (@(posedge clk) disable iff (rst)
    (rsp_unloaded_fault || rsp_miss_fault) |-> rsp_paddr == '0);

  a_r12_fill_answer: assert property (@(posedge clk) disable iff (rst)
    fill_valid |=> (fill_done != fill_reject));

  a_r12_no_spurious_ack: assert property (@(posedge clk) disable iff (rst)
    !fill_valid |=> !(fill_done || fill_reject));

  a_r8_resident_kept: assert property (@(posedge clk) disable iff (rst)
    evict_en |-> !resident_vec[victim_idx]);

endmodule

bind xlate_unit xlate_checker #(
  .ADDR_W(ADDR_W), .OFS_W(OFS_W), .ENTRIES(ENTRIES)
) u_chk (
  .clk                (clk),
  .rst                (rst),
  .req_valid          (req_valid),
  .req_vaddr          (req_vaddr),
  .rsp_valid          (rsp_valid),
  .rsp_hit            (rsp_hit),
  .rsp_paddr          (rsp_paddr),
  .rsp_miss_fault     (rsp_miss_fault),
  .rsp_unloaded_fault (rsp_unloaded_fault),
  .fill_valid         (fill_valid),
  .fill_done          (fill_done),
  .fill_reject        (fill_reject),
  .evict_en           (evict_en),
  .victim_idx         (victim_idx),
  .resident_vec       (resident_vec)
);

// File: tb/tb_xlate_unit.sv
module tb_xlate_unit;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic [31:0] req_vaddr;
  logic        rsp_valid, rsp_hit, rsp_miss_fault, rsp_unloaded_fault;
  logic [31:0] rsp_paddr;
  logic        fill_valid, fill_loaded, fill_resident;
  logic [19:0] fill_vpn, fill_ppn;
  logic        fill_done, fill_reject;
  logic        mark_valid;
  logic [19:0] mark_vpn;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xlate_unit dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_vaddr(req_vaddr),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr),
    .rsp_miss_fault(rsp_miss_fault), .rsp_unloaded_fault(rsp_unloaded_fault),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
    .fill_loaded(fill_loaded), .fill_resident(fill_resident),
    .fill_done(fill_done), .fill_reject(fill_reject),
    .mark_valid(mark_valid), .mark_vpn(mark_vpn)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    req_valid = 0; req_vaddr = '0;
    fill_valid = 0; fill_vpn = '0; fill_ppn = '0; fill_loaded = 0; fill_resident = 0;
    mark_valid = 0; mark_vpn = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; idle_inputs();
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  // lookup: drive at a falling edge, read the registered result one cycle later
  task automatic lookup(input logic [31:0] va, output logic v, output logic h,
                        output logic m, output logic u, output logic [31:0] pa);
    req_valid = 1; req_vaddr = va;
    @(negedge clk);
    req_valid = 0;
    v = rsp_valid; h = rsp_hit; m = rsp_miss_fault; u = rsp_unloaded_fault; pa = rsp_paddr;
  endtask

  task automatic expect_hit(input string tag, input logic [31:0] va, input logic [31:0] pa_exp);
    logic v, h, m, u; logic [31:0] pa;
    lookup(va, v, h, m, u, pa);
    check({tag, " valid"}, 32'(v), 32'd1);
    check({tag, " hit"},   32'(h), 32'd1);
    check({tag, " paddr"}, pa, pa_exp);
  endtask

  task automatic expect_miss(input string tag, input logic [31:0] va);
    logic v, h, m, u; logic [31:0] pa;
    lookup(va, v, h, m, u, pa);
    check({tag, " flags v/h/m/u"}, {28'd0, v, h, m, u}, 32'b1010);
    check({tag, " paddr"}, pa, 32'd0);
  endtask

  task automatic expect_unloaded(input string tag, input logic [31:0] va);
    logic v, h, m, u; logic [31:0] pa;
    lookup(va, v, h, m, u, pa);
    check({tag, " flags v/h/m/u"}, {28'd0, v, h, m, u}, 32'b1001);
    check({tag, " paddr"}, pa, 32'd0);
  endtask

  task automatic fill(input string tag, input logic [19:0] vpn, input logic [19:0] ppn,
                      input logic ld, input logic res, input logic exp_ok);
    fill_valid = 1; fill_vpn = vpn; fill_ppn = ppn; fill_loaded = ld; fill_resident = res;
    @(negedge clk);
    fill_valid = 0;
    check({tag, " R12 done/reject"}, {30'd0, fill_done, fill_reject}, exp_ok ? 32'b10 : 32'b01);
  endtask

  task automatic mark(input logic [19:0] vpn);
    mark_valid = 1; mark_vpn = vpn;
    @(negedge clk);
    mark_valid = 0;
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    do_reset();
    check("R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
    check("R1 fill acks after reset", {30'd0, fill_done, fill_reject}, 32'd0);
    expect_miss("R1 R4 first lookup", 32'h1234_5678);
    @(negedge clk);
    check("R5 idle outputs", {28'd0, rsp_valid, rsp_hit, rsp_miss_fault, rsp_unloaded_fault}, 32'd0);
  endtask

  task automatic t_basic_hit();
    do_reset();
    fill("basic", 20'h12345, 20'hABCDE, 1'b1, 1'b0, 1'b1);
    @(negedge clk);
    check("R12 done is one pulse", {30'd0, fill_done, fill_reject}, 32'd0);
    expect_hit("R2 loaded hit", 32'h1234_5678, 32'hABCD_E678);
    expect_hit("R2 other offset", 32'h1234_5FFF, 32'hABCD_EFFF);
    expect_miss("R4 neighbour page", 32'h1234_6000);
  endtask

  task automatic t_unloaded();
    do_reset();
    fill("unl", 20'h00400, 20'h00777, 1'b0, 1'b0, 1'b1);
    expect_unloaded("R3 mapped not loaded", 32'h0040_0ABC);
    mark(20'h99999);
    expect_unloaded("R10 foreign mark ignored", 32'h0040_0ABC);
    mark(20'h00400);
    expect_hit("R10 mark sets loaded", 32'h0040_0ABC, 32'h0077_7ABC);
  endtask

  task automatic t_same_cycle();
    logic v, h, m, u; logic [31:0] pa;
    do_reset();
    // refill and lookup of the same page taken at one edge
    fill_valid = 1; fill_vpn = 20'h0F0F0; fill_ppn = 20'h11111; fill_loaded = 1; fill_resident = 0;
    lookup(32'h0F0F_0123, v, h, m, u, pa);
    fill_valid = 0;
    check("R13 lookup before refill misses", {28'd0, v, h, m, u}, 32'b1010);
    expect_hit("R13 next lookup hits", 32'h0F0F_0123, 32'h1111_1123);
    // mark and lookup at one edge
    fill("mk", 20'h0A0A0, 20'h22222, 1'b0, 1'b0, 1'b1);
    mark_valid = 1; mark_vpn = 20'h0A0A0;
    lookup(32'h0A0A_0004, v, h, m, u, pa);
    mark_valid = 0;
    check("R13 lookup before mark unloaded", {28'd0, v, h, m, u}, 32'b1001);
    expect_hit("R13 after mark", 32'h0A0A_0004, 32'h2222_2004);
  endtask

  task automatic t_duplicate();
    do_reset();
    fill("dup0", 20'h55555, 20'h00001, 1'b1, 1'b0, 1'b1);
    fill("dup1", 20'h55555, 20'h00002, 1'b1, 1'b0, 1'b1);
    expect_hit("R11 lowest index wins", 32'h5555_5010, 32'h0000_1010);
  endtask

  task automatic t_round_robin();
    do_reset();
    for (int i = 0; i < 8; i++)
      fill("rr fill", 20'h10000 + 20'(i), 20'h20000 + 20'(i), 1'b1, 1'b0, 1'b1);
    for (int i = 0; i < 8; i++)
      expect_hit("R6 all kept", {20'h10000 + 20'(i), 12'h040}, {20'h20000 + 20'(i), 12'h040});
    fill("rr ev0", 20'h30000, 20'h3A000, 1'b1, 1'b0, 1'b1);
    expect_miss("R7 entry 0 replaced", 32'h1000_0000);
    expect_hit("R7 entry 1 kept", 32'h1000_1000, 32'h2000_1000);
    expect_hit("R7 new mapping", 32'h3000_0008, 32'h3A00_0008);
    fill("rr ev1", 20'h30001, 20'h3A001, 1'b1, 1'b0, 1'b1);
    expect_miss("R7 entry 1 replaced", 32'h1000_1000);
    expect_hit("R7 entry 2 kept", 32'h1000_2000, 32'h2000_2000);
    expect_hit("R7 first new kept", 32'h3000_0008, 32'h3A00_0008);
  endtask

  task automatic t_resident();
    do_reset();
    fill("res0", 20'h40000, 20'h4F000, 1'b1, 1'b1, 1'b1);
    for (int i = 1; i < 8; i++)
      fill("res fill", 20'h40000 + 20'(i), 20'h4F000 + 20'(i), 1'b1, 1'b0, 1'b1);
    fill("res ev", 20'h50000, 20'h5F000, 1'b1, 1'b0, 1'b1);
    expect_hit("R8 pinned entry kept", 32'h4000_0100, 32'h4F00_0100);
    expect_miss("R8 entry 1 replaced instead", 32'h4000_1100);
    fill("res ev2", 20'h50001, 20'h5F001, 1'b1, 1'b0, 1'b1);
    expect_miss("R7 entry 2 replaced next", 32'h4000_2100);
    expect_hit("R8 pinned still kept", 32'h4000_0100, 32'h4F00_0100);
  endtask

  task automatic t_all_resident();
    do_reset();
    for (int i = 0; i < 8; i++)
      fill("pin fill", 20'h60000 + 20'(i), 20'h6F000 + 20'(i), 1'b1, 1'b1, 1'b1);
    fill("R9 full of pinned", 20'h70000, 20'h7F000, 1'b1, 1'b0, 1'b0);
    expect_miss("R9 rejected mapping absent", 32'h7000_0000);
    for (int i = 0; i < 8; i++)
      expect_hit("R9 pinned unchanged", {20'h60000 + 20'(i), 12'h3C0}, {20'h6F000 + 20'(i), 12'h3C0});
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WATCHDOG);
        finish_run();
      end
    end
  end

  initial begin
    rst = 1;
    idle_inputs();
    t_reset();
    t_basic_hit();
    t_unloaded();
    t_same_cycle();
    t_duplicate();
    t_round_robin();
    t_resident();
    t_all_resident();
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule